// File: doc/BRIEF.md
# Paired Sample Frame Packer with Block-Ready Counter

This block sits between a serial readout master and a host transfer port. The readout side delivers 22-bit sample frames one at a time with a valid strobe. The packer pairs consecutive frames into a byte-aligned 64-bit word and stores each word in an on-chip FIFO. It also keeps a live count of the words held.

A host agent watches a block-ready flag. The flag rises once the FIFO holds at least one full block of words, 2048 by default. The host then drains that block as a burst through a read-enable port with one cycle of read latency.

A frame left without a partner waits in a staging register until the next frame arrives. A flush input pushes it out alone.

Top module: `frame_packer`

## Requirements
- R1: Each stored word places the older frame of a pair in bits [21:0] and the newer frame in bits [53:32]. Bits [31:22] and [63:54] are always zero.
- R2: Frames are paired strictly in arrival order. An odd frame stays staged and produces no word until its partner arrives.
- R3: A word produced while the FIFO holds DEPTH words is discarded. The occupancy count does not change, and a sticky overflow flag is set and stays set until reset.
- R4: The occupancy output rises by one for each stored word and falls by one for each accepted read. A stored word and an accepted read in the same cycle leave it unchanged.
- R5: A read request while occupancy is zero is ignored. The read-valid output stays low and occupancy stays zero.
- R6: blockReady is high exactly when occupancy is at least BLOCK (2048 by default).
- R7: Flush with a staged frame and no incoming frame stores that frame alone, with the upper half zero. Flush together with an incoming frame and an empty stage stores the incoming frame alone. Flush with nothing staged and no incoming frame does nothing.
- R8: After reset, occupancy is zero, and blockReady, overflow and rdValid are low.
- R9: An accepted read returns the oldest stored word on rdData in the following cycle, with rdValid high in that cycle only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| frameValid | input | 1 | Incoming frame strobe |
| frameData | input | 22 | Incoming sample frame |
| flush | input | 1 | Force out a lone staged or incoming frame |
| rdEn | input | 1 | Host read request |
| rdData | output | 64 | Word returned by an accepted read |
| rdValid | output | 1 | rdData holds a fresh word this cycle |
| occupancy | output | 12 | Words currently stored |
| blockReady | output | 1 | At least one full block is stored |
| overflow | output | 1 | Sticky flag: a word was dropped while full |

## Verification
The embedded properties check several rules on every cycle:
- occupancy never exceeds the depth;
- a write into a full FIFO leaves the count alone;
- the overflow flag never clears;
- a flush empties the stage;
- rdValid only follows a cycle with a non-zero count;
- blockReady only rises from one word below a block;
- no stored word carries non-zero padding.

Data integrity cannot be shown that way and needs the bench scenarios. That covers pairing order, FIFO ordering across a full-depth fill and burst drain, the exact contents of flushed words, and the moment blockReady first asserts.

// File: rtl/framepack_pkg.sv
package framepack_pkg;
  typedef struct packed {
    logic stageLoad;
    logic pushPair;
    logic pushSingle;
    logic singleFromInput;
    logic pushOk;
    logic popOk;
  } packStrobe_t;
endpackage

// File: rtl/packer_ctrl.sv
module packer_ctrl
  import framepack_pkg::*;
#(
  parameter int DEPTH = 2048,
  parameter int BLOCK = 2048,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          frameValid,
  input  logic          flush,
  input  logic          rdEn,
  output packStrobe_t   strobe,
  output logic [AW-1:0] wrAddr,
  output logic [AW-1:0] rdAddr,
  output logic [CW-1:0] occupancy,
  output logic          blockReady,
  output logic          overflow
);
  logic stageFull;
  logic pushWant;
  logic fifoFull;

  assign fifoFull   = (occupancy == CW'(DEPTH));
  assign blockReady = (occupancy >= CW'(BLOCK));

  always_comb begin
    strobe = '0;
    if (frameValid && stageFull) begin
      strobe.pushPair = 1'b1;
    end else if (frameValid && flush) begin
      strobe.pushSingle      = 1'b1;
      strobe.singleFromInput = 1'b1;
    end else if (frameValid) begin
      strobe.stageLoad = 1'b1;
    end else if (flush && stageFull) begin
      strobe.pushSingle = 1'b1;
    end
    pushWant     = strobe.pushPair | strobe.pushSingle;
    strobe.pushOk = pushWant && !fifoFull;
    strobe.popOk  = rdEn && (occupancy != '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stageFull <= 1'b0;
      wrAddr    <= '0;
      rdAddr    <= '0;
      occupancy <= '0;
      overflow  <= 1'b0;
    end else begin
      if (strobe.stageLoad) stageFull <= 1'b1;
      else if (pushWant)    stageFull <= 1'b0;

      if (strobe.pushOk)
        wrAddr <= (wrAddr == AW'(DEPTH - 1)) ? '0 : wrAddr + 1'b1;
      if (strobe.popOk)
        rdAddr <= (rdAddr == AW'(DEPTH - 1)) ? '0 : rdAddr + 1'b1;

      if (strobe.pushOk && !strobe.popOk)      occupancy <= occupancy + 1'b1;
      else if (!strobe.pushOk && strobe.popOk) occupancy <= occupancy - 1'b1;

      if (pushWant && fifoFull) overflow <= 1'b1;
    end
  end

  p_occ_range_r4: assert property (@(posedge clk) disable iff (!rstN)
    occupancy <= CW'(DEPTH));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rstN)
    (pushWant && fifoFull && !rdEn) |=> (occupancy == $past(occupancy)));

  p_ovf_sticky_r3: assert property (@(posedge clk) disable iff (!rstN)
    overflow |=> overflow);

  p_flush_clears_r7: assert property (@(posedge clk) disable iff (!rstN)
    (flush && stageFull) |=> !stageFull);
endmodule

// File: rtl/packer_data.sv
module packer_data
  import framepack_pkg::*;
#(
  parameter int DEPTH   = 2048,
  parameter int FRAME_W = 22,
  parameter int WORD_W  = 64,
  localparam int AW   = $clog2(DEPTH),
  localparam int HALF = WORD_W / 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  packStrobe_t        strobe,
  input  logic [AW-1:0]      wrAddr,
  input  logic [AW-1:0]      rdAddr,
  input  logic [FRAME_W-1:0] frameData,
  output logic [WORD_W-1:0]  rdData,
  output logic               rdValid
);
  logic [FRAME_W-1:0] stageReg;
  logic [WORD_W-1:0]  wrWord;
  logic [WORD_W-1:0]  mem [DEPTH];

  function automatic logic [WORD_W-1:0] packWord(input logic [FRAME_W-1:0] lo,
                                                 input logic [FRAME_W-1:0] hi);
    logic [WORD_W-1:0] w;
    w = '0;
    w[FRAME_W-1:0]           = lo;
    w[HALF+FRAME_W-1:HALF]   = hi;
    return w;
  endfunction

  always_comb begin
    if (strobe.pushPair)             wrWord = packWord(stageReg, frameData);
    else if (strobe.singleFromInput) wrWord = packWord(frameData, '0);
    else                             wrWord = packWord(stageReg, '0);
  end

  always_ff @(posedge clk) begin
    if (strobe.stageLoad) stageReg <= frameData;
    if (strobe.pushOk)    mem[wrAddr] <= wrWord;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdValid <= 1'b0;
      rdData  <= '0;
    end else begin
      rdValid <= strobe.popOk;
      if (strobe.popOk) rdData <= mem[rdAddr];
    end
  end

  p_pad_zero_r1: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pushOk |-> (wrWord[HALF-1:FRAME_W] == '0 &&
                       wrWord[WORD_W-1:HALF+FRAME_W] == '0));
endmodule

// File: rtl/frame_packer.sv
module frame_packer
  import framepack_pkg::*;
#(
  parameter int DEPTH   = 2048,
  parameter int BLOCK   = 2048,
  parameter int FRAME_W = 22,
  parameter int WORD_W  = 64,
  localparam int AW = $clog2(DEPTH),
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               frameValid,
  input  logic [FRAME_W-1:0] frameData,
  input  logic               flush,
  input  logic               rdEn,
  output logic [WORD_W-1:0]  rdData,
  output logic               rdValid,
  output logic [CW-1:0]      occupancy,
  output logic               blockReady,
  output logic               overflow
);
  packStrobe_t   strobe;
  logic [AW-1:0] wrAddr;
  logic [AW-1:0] rdAddr;

  packer_ctrl #(.DEPTH(DEPTH), .BLOCK(BLOCK)) u_ctrl (
    .clk(clk), .rstN(rstN), .frameValid(frameValid), .flush(flush),
    .rdEn(rdEn), .strobe(strobe), .wrAddr(wrAddr), .rdAddr(rdAddr),
    .occupancy(occupancy), .blockReady(blockReady), .overflow(overflow)
  );

  packer_data #(.DEPTH(DEPTH), .FRAME_W(FRAME_W), .WORD_W(WORD_W)) u_data (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrAddr(wrAddr),
    .rdAddr(rdAddr), .frameData(frameData), .rdData(rdData),
    .rdValid(rdValid)
  );

  p_empty_read_r5: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |-> ($past(occupancy) != '0));

  p_ready_edge_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(blockReady) |-> ($past(occupancy) == CW'(BLOCK - 1)));
endmodule

// File: tb/frame_packer_test.sv
module frame_packer_test;
  localparam int DEPTH = 2048;
  localparam int BLOCK = 2048;

  logic        clk = 1'b0;
  logic        rstN;
  logic        frameValid;
  logic [21:0] frameData;
  logic        flush;
  logic        rdEn;
  logic [63:0] rdData;
  logic        rdValid;
  logic [11:0] occupancy;
  logic        blockReady;
  logic        overflow;

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // model state
  logic [63:0] q[$];
  bit          mStage = 0;
  logic [21:0] mStageVal = '0;
  bit          mOvf = 0;
  bit          mRdValid = 0;
  logic [63:0] mRdData = '0;

  always #2 clk = ~clk;

  frame_packer uut (
    .clk(clk), .rstN(rstN), .frameValid(frameValid), .frameData(frameData),
    .flush(flush), .rdEn(rdEn), .rdData(rdData), .rdValid(rdValid),
    .occupancy(occupancy), .blockReady(blockReady), .overflow(overflow)
  );

  function automatic logic [63:0] packExp(input logic [21:0] lo,
                                          input logic [21:0] hi);
    return {10'b0, hi, 10'b0, lo};
  endfunction

  task automatic check(input string req, input logic [63:0] act,
                       input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input bit fv, input logic [21:0] fd, input bit fl,
                      input bit re);
    bit pushWant;
    bit popOk;
    logic [63:0] w;
    int sizePre;
    frameValid = fv; frameData = fd; flush = fl; rdEn = re;
    @(posedge clk);
    sizePre  = q.size();
    popOk    = re && sizePre != 0;
    pushWant = 0;
    w        = '0;
    if (fv && mStage) begin
      pushWant = 1; w = packExp(mStageVal, fd); mStage = 0;
    end else if (fv && fl) begin
      pushWant = 1; w = packExp(fd, '0);
    end else if (fv) begin
      mStage = 1; mStageVal = fd;
    end else if (fl && mStage) begin
      pushWant = 1; w = packExp(mStageVal, '0); mStage = 0;
    end
    mRdValid = popOk;
    if (popOk) mRdData = q.pop_front();
    if (pushWant) begin
      if (sizePre < DEPTH) q.push_back(w);
      else mOvf = 1;
    end
    @(negedge clk);
    frameValid = 0; flush = 0; rdEn = 0;
    check("R4 occupancy", 64'(occupancy), 64'(q.size()));
    check("R6 blockReady", 64'(blockReady), 64'(q.size() >= BLOCK));
    check("R3 overflow", 64'(overflow), 64'(mOvf));
    check("R9 rdValid", 64'(rdValid), 64'(mRdValid));
    if (mRdValid) check("R1 R2 rdData", rdData, mRdData);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish();
  end

  initial begin
    logic [21:0] a;
    logic [21:0] b;
    void'($urandom(32'd1234));
    rstN = 0; frameValid = 0; frameData = '0; flush = 0; rdEn = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1;
    // R8 reset state
    check("R8 occupancy", 64'(occupancy), 0);
    check("R8 blockReady", 64'(blockReady), 0);
    check("R8 overflow", 64'(overflow), 0);
    check("R8 rdValid", 64'(rdValid), 0);

    // R5 read while empty
    step(0, '0, 0, 1);
    check("R5 empty read", {63'(occupancy), rdValid}, 0);

    // R2 one frame stays staged
    a = 22'h3ABCDE; b = 22'h012345;
    step(1, a, 0, 0);
    check("R2 staged no word", 64'(occupancy), 0);
    step(1, b, 0, 0);
    step(0, '0, 0, 1);
    check("R1 pair layout", rdData, 64'h0001_2345_003A_BCDE);

    // R7 flush staged frame, flush with input, flush with nothing
    step(1, 22'h2AAAAA, 0, 0);
    step(0, '0, 1, 0);
    step(1, 22'h155555, 1, 0);
    step(0, '0, 1, 0);
    check("R7 flush idle", 64'(occupancy), 2);
    step(0, '0, 0, 1);
    check("R7 flushed stage", rdData, 64'h0000_0000_002A_AAAA);
    step(0, '0, 0, 1);
    check("R7 flushed input", rdData, 64'h0000_0000_0015_5555);

    // R4 simultaneous push and pop
    step(1, 22'h1, 0, 0);
    step(1, 22'h2, 0, 0);
    step(1, 22'h3, 0, 0);
    step(1, 22'h4, 0, 1);
    check("R4 push+pop same", 64'(occupancy), 1);
    step(0, '0, 0, 1);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      step(($urandom % 10) < 6, 22'($urandom), ($urandom % 16) == 0,
           ($urandom % 2) == 1);
    end
    // drain and clear stage
    step(0, '0, 1, 0);
    while (q.size() != 0) step(0, '0, 0, 1);

    // R6 fill to block boundary
    for (int i = 0; i < 2 * BLOCK - 2; i++) step(1, 22'(i * 7 + 3), 0, 0);
    check("R6 below block", 64'(blockReady), 0);
    step(1, 22'h3FFFFF, 0, 0);
    step(1, 22'h2F0F0F, 0, 0);
    check("R6 at block", 64'(blockReady), 1);

    // R3 overflow while full
    step(1, 22'h111111, 0, 0);
    step(1, 22'h222222, 0, 0);
    check("R3 count held", 64'(occupancy), DEPTH);
    check("R3 flag set", 64'(overflow), 1);

    // burst drain
    for (int i = 0; i < BLOCK; i++) step(0, '0, 0, 1);
    check("R9 drained", 64'(occupancy), 0);
    check("R3 sticky", 64'(overflow), 1);
    step(0, '0, 0, 1);
    check("R5 empty after drain", 64'(rdValid), 0);
    finish();
  end
endmodule